// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block exchanges 32-bit words among the lanes of a warp in a single step. Each lane selects a source lane using one of four addressing modes: shift toward lower lanes, shift toward higher lanes, XOR swap, or direct index. It then takes that lane's word. A control word carries a segment mask and a clamp lane. Together they split the warp into independent sub-groups and bound how far a lane may reach. When a source falls outside the allowed range, the lane keeps its own word and clears its predicate bit. When the chosen source lane is inactive, the lane's result is zero.

All lanes are computed in parallel from the inputs sampled on a start pulse. The results are registered. A done pulse follows one cycle later, and the results hold until the next start.

Top module: `lane_shuffle`

## Requirements
- R1: After reset, `done`, every word of `res_out` and every bit of `pred_out` are zero.
- R2: The segment mask is `seg_ctl[12:8]` and the clamp lane is `seg_ctl[4:0]`. All other bits of `seg_ctl` have no effect. For lane L, hi = (L & mask) | (clamp & ~mask) and lo = L & mask.
- R3: Mode 0 (`mode`=2'b00) selects source L - `lane_sel`. The source is valid when it is non-negative and >= hi.
- R4: Mode 1 (2'b01) selects source L + `lane_sel`. The source is valid when it is <= hi.
- R5: Mode 2 (2'b10) selects source L ^ `lane_sel`. The source is valid when it is <= hi.
- R6: Mode 3 (2'b11) selects source lo | (`lane_sel` & ~mask). The source is valid when it is <= hi.
- R7: When a lane's source is invalid, the lane uses its own index as the source. Its bit in `pred_out` is 0 when the source is invalid and 1 when it is valid.
- R8: A lane's result is word S of `data_in` (bits 32S+31:32S) if `act_mask[S]` is 1, where S is the final source lane. Otherwise the result is zero.
- R9: `done` is high exactly in the cycle after a cycle with `start` high, and low otherwise.
- R10: `res_out` and `pred_out` change only on the edge that samples `start` high. Input changes without `start` leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample inputs and compute |
| mode | input | 2 | Addressing mode |
| lane_sel | input | 5 | Offset, XOR pattern or index |
| seg_ctl | input | 32 | Segment mask and clamp lane |
| act_mask | input | 32 | Active lanes |
| data_in | input | 1024 | Lane words, lane i at bits 32i+31:32i |
| done | output | 1 | Result-ready pulse |
| res_out | output | 1024 | Result words, same packing |
| pred_out | output | 32 | Per-lane source-valid flag |

## Verification
Directed cases cover each mode with a full-warp clamp. They separate the four source formulas, and the low-lane invalid window of the upward shift exercises the own-value fallback. A segmented control word with extra junk bits checks that only the mask and clamp fields steer the sources. Sparse and empty active masks distinguish zero fill from copying. Random operands, masks and data across all modes then compare every lane's word and predicate against an independent model, and an input change without `start` confirms the results hold.

// File: rtl/lane_shuffle.sv
module lane_shuffle #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic [$clog2(LANES)-1:0] lane_sel,
  input  logic [31:0]           seg_ctl,
  input  logic [LANES-1:0]      act_mask,
  input  logic [LANES*DW-1:0]   data_in,
  output logic                  done,
  output logic [LANES*DW-1:0]   res_out,
  output logic [LANES-1:0]      pred_out
);
  localparam int LW = $clog2(LANES);
  localparam logic [1:0] M_UP = 2'd0, M_DOWN = 2'd1, M_XOR = 2'd2, M_IDX = 2'd3;

  logic [LW-1:0] seg_mask, clamp;
  logic          unused_ctl;
  assign seg_mask   = seg_ctl[8 +: LW];
  assign clamp      = seg_ctl[LW-1:0];
  assign unused_ctl = ^{seg_ctl[31:8+LW], seg_ctl[7:LW]};

  logic [DW-1:0]       din [LANES];
  logic [LANES*DW-1:0] nxt_res;
  logic [LANES-1:0]    nxt_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] me, hi, lo, pick;
    logic [LW:0]   src;
    logic          ok;

    assign din[g] = data_in[g*DW +: DW];
    assign me     = LW'(g);
    assign hi     = (me & seg_mask) | (clamp & ~seg_mask);
    assign lo     = me & seg_mask;

    always_comb begin
      case (mode)
        M_UP: begin
          src = {1'b0, me} - {1'b0, lane_sel};
          ok  = !src[LW] && (src[LW-1:0] >= hi);
        end
        M_DOWN: begin
          src = {1'b0, me} + {1'b0, lane_sel};
          ok  = src <= {1'b0, hi};
        end
        M_XOR: begin
          src = {1'b0, me ^ lane_sel};
          ok  = src[LW-1:0] <= hi;
        end
        default: begin
          src = {1'b0, lo | (lane_sel & ~seg_mask)};
          ok  = src[LW-1:0] <= hi;
        end
      endcase
    end

    assign pick              = ok ? src[LW-1:0] : me;
    assign nxt_ok[g]         = ok;
    assign nxt_res[g*DW +: DW] = act_mask[pick] ? din[pick] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      res_out  <= '0;
      pred_out <= '0;
    end else begin
      done <= start;
      if (start) begin
        res_out  <= nxt_res;
        pred_out <= nxt_ok;
      end
    end
  end
endmodule

module lane_shuffle_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [1:0]                mode,
  input logic [$clog2(LANES)-1:0]  lane_sel,
  input logic [LANES-1:0]          act_mask,
  input logic                      done,
  input logic [LANES*DW-1:0]       res_out,
  input logic [LANES-1:0]          pred_out
);
  // R9
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R9
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(res_out) && $stable(pred_out)));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && act_mask == '0) |=> (res_out == '0));
  // R3
  up_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd0 && lane_sel != '0) |=> !pred_out[0]);
endmodule

bind lane_shuffle lane_shuffle_chk #(.LANES(LANES), .DW(DW)) chk_i (.*);

// File: tb/lane_shuffle_test.sv
`timescale 1ns/1ps
module lane_shuffle_test;
  localparam int N = 32;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0;
  logic [4:0] lane_sel = 0;
  logic [31:0] seg_ctl = 0, act_mask = 0;
  logic [N*W-1:0] data_in = '0;
  logic done;
  logic [N*W-1:0] res_out;
  logic [N-1:0] pred_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lane_shuffle uut (.clk, .rst_n, .start, .mode, .lane_sel, .seg_ctl,
                    .act_mask, .data_in, .done, .res_out, .pred_out);

  function automatic void model(input int m, input int b, input logic [31:0] c,
      input logic [31:0] act, input logic [N*W-1:0] d,
      output logic [N*W-1:0] r, output logic [31:0] p);
    int msk, clp, hi, lo, src;
    bit ok;
    msk = (c >> 8) & 31;
    clp = c & 31;
    for (int l = 0; l < N; l++) begin
      hi = (l & msk) | (clp & ~msk & 31);
      lo = l & msk;
      case (m)
        0: begin src = l - b; ok = (src >= hi); end
        1: begin src = l + b; ok = (src <= hi); end
        2: begin src = l ^ b; ok = (src <= hi); end
        default: begin src = lo | (b & ~msk & 31); ok = (src <= hi); end
      endcase
      if (!ok) src = l;
      p[l] = ok;
      r[l*W +: W] = act[src] ? d[src*W +: W] : '0;
    end
  endfunction

  task automatic chk(input bit good, input string req, input string what,
                     input logic [N*W-1:0] act_v, input logic [N*W-1:0] exp_v);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic run(input int m, input int b, input logic [31:0] c,
                     input logic [31:0] act, input string req);
    logic [N*W-1:0] er;
    logic [31:0] ep;
    @(negedge clk);
    for (int l = 0; l < N; l++) data_in[l*W +: W] = $urandom;
    mode = m[1:0]; lane_sel = b[4:0]; seg_ctl = c; act_mask = act; start = 1;
    model(m, b, c, act, data_in, er, ep);
    @(negedge clk);
    start = 0;
    chk(done === 1'b1, "R9", "done pulse", {1023'b0, done}, 1);
    chk(pred_out === ep, req, "pred", pred_out, ep);
    chk(res_out === er, req, "result", res_out, er);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done single", {1023'b0, done}, 0);
  endtask

  initial begin
    logic [N*W-1:0] hr;
    logic [N-1:0] hp;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(done === 0 && res_out === '0 && pred_out === '0, "R1", "reset state",
        res_out, 0);
    rst_n = 1;
    run(0, 3, 32'h0, 32'hFFFF_FFFF, "R3");
    run(0, 3, 32'h0, 32'hFFFF_FFFF, "R7");
    run(1, 1, 32'h1F, 32'hFFFF_FFFF, "R4");
    run(1, 5, 32'h1F, 32'hFFFF_FFFF, "R7");
    run(2, 1, 32'h1F, 32'hFFFF_FFFF, "R5");
    run(2, 16, 32'h1F, 32'hFFFF_FFFF, "R5");
    run(3, 5, 32'h1F, 32'hFFFF_FFFF, "R6");
    run(3, 2, 32'h0000_1807, 32'hFFFF_FFFF, "R6");
    run(1, 2, 32'h0000_1807, 32'hFFFF_FFFF, "R2");
    run(1, 2, 32'hABCD_F8E7, 32'hFFFF_FFFF, "R2");
    run(0, 1, 32'hFFFF_E0E0, 32'hFFFF_FFFF, "R2");
    run(1, 1, 32'h1F, 32'h0000_FFFF, "R8");
    run(2, 1, 32'h1F, 32'h0, "R8");
    hr = res_out; hp = pred_out;
    @(negedge clk);
    mode = 2'd3; lane_sel = 5'd9; act_mask = 32'hFFFF_FFFF; data_in = ~data_in;
    repeat (4) @(negedge clk);
    chk(res_out === hr && pred_out === hp, "R10", "hold", res_out, hr);
    for (int i = 0; i < 200; i++) begin
      int m;
      m = $urandom_range(0, 3);
      run(m, $urandom_range(0, 31), $urandom, $urandom,
          m == 0 ? "R3" : m == 1 ? "R4" : m == 2 ? "R5" : "R6");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule